// File: doc/BRIEF.md
# Fail-Closed Fuse Read Window

This block gives machine-mode software a read-only view onto a small one-time-programmable fuse array through a 32-bit register window at base address 0x0000_3000. Every read passes through fail-closed rules. A fuse word that was never programmed reads as all-ones. Any word that is locked or lies outside the array reads as zero. A requester below machine privilege gets zero data and an error response.

Two sticky latches sit beside the array, and both clear only on reset. The first is the window-disable latch. Once it is set, every later access is refused until the next reset; software sets it before it hands control to later boot stages. The second is the key-erase latch. Once it is set, the eight words of the root public-key hash read as zero.

Requests arrive on a valid/ready channel and responses leave on a second valid/ready channel with a fixed one-cycle latency. The block holds one response register. While that response waits for `rsp_ready`, `req_ready` stays low, so back-pressure on the response side stalls the request side. A response that has been presented stays stable until the consumer takes it. The fuse contents come from a behavioural array. The `prog_*` pins load that array after reset, standing in for real fuse sensing.

Top module: `fuse_window`

## Requirements
- R1: An accepted machine-mode (`req_priv` = 2'b11) read of a programmed word inside the window returns that word on `rsp_rdata` with `rsp_err` low. `rsp_valid` is high in the cycle after the acceptance edge.
- R2: A read of a fuse word whose programmed flag is clear returns 0xFFFF_FFFF.
- R3: A request whose `req_priv` is not 2'b11 gets `rsp_err` high and zero data. A write from such a requester changes no latch.
- R4: Any write to offset 0x034 sets the key-erase latch. After that, offsets 0x010–0x02F read zero. A read of offset 0x034 returns 1 in bit 0 while the latch is set and 0 before it is set.
- R5: A read at an address whose low two bits are not zero returns bytes of the addressed word and the next word in little-endian order, so the result equals ({next, word} >> 8·addr[1:0])[31:0]. If either word is locked, the result is zero.
- R6: A write to offset 0x030 with `req_wdata` bit 3 = 1 sets the window-disable latch. From then on every request gets `rsp_err` high and zero data. The same write with bit 3 = 0 has no effect.
- R7: Writes to any other offset are ignored and get no error. Words read back unchanged afterwards.
- R8: An address outside 0x0000_3000–0x0000_3FFF gets `rsp_err` high. A window offset at or above 4·NUM_WORDS reads zero with no error.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_rdata`/`rsp_err` hold their values.
- R10: Both latches clear only on reset. After a reset the window serves reads again and offset 0x034 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears latches, response state and the model's programmed flags |
| prog_we | input | 1 | Load strobe for the behavioural fuse model |
| prog_idx | input | IDX_W (6) | Word index to load |
| prog_data | input | 32 | Word value to load; also sets the word's programmed flag |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| req_priv | input | 2 | Requester privilege, 2'b11 = machine |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data (zero on writes and errors) |
| rsp_err | output | 1 | Access refused |

## Verification
Reads are tried on programmed words, unprogrammed words, the erase-latch word and offsets past the array, which separates stored data, the all-ones default and the zero of a locked word. Misaligned reads within unlocked words, and across the boundary into the root hash before and after erasure, show the byte order and the fact that one locked neighbour zeroes the whole result. Writes from supervisor and user privilege, to read-only offsets, and to the policy word with bit 3 clear and then set show that only the intended paths change state. A stalled response and a reset after both latches are set cover back-pressure and stickiness.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam logic [1:0] PRIV_MACHINE = 2'b11;
  localparam int OFF_W  = 12;
  localparam int WIDX_W = OFF_W - 2;
  localparam logic [31:0] WIN_BASE = 32'h0000_3000;
  localparam logic [WIDX_W-1:0] IDX_POLICY  = WIDX_W'(12);
  localparam logic [WIDX_W-1:0] IDX_ERASE   = WIDX_W'(13);
  localparam logic [WIDX_W-1:0] IDX_ROOT_LO = WIDX_W'(4);
  localparam logic [WIDX_W-1:0] IDX_ROOT_HI = WIDX_W'(11);
  localparam int DISABLE_BIT = 3;

  typedef struct packed {
    logic [31:0] data;
    logic        prog;
  } fuse_word_t;
endpackage

// File: rtl/fuse_array.sv
module fuse_array
  import fuse_pkg::*;
#(
  parameter int NUM_WORDS = 64,
  parameter int IDX_W = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_we,
  input  logic [IDX_W-1:0]  prog_idx,
  input  logic [31:0]       prog_data,
  input  logic [WIDX_W-1:0] rd_idx_a,
  input  logic [WIDX_W-1:0] rd_idx_b,
  output fuse_word_t        rd_a,
  output fuse_word_t        rd_b
);
  logic [31:0]          mem [NUM_WORDS];
  logic [NUM_WORDS-1:0] written;

  always_ff @(posedge clk) begin
    if (prog_we) mem[prog_idx] <= prog_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       written <= '0;
    else if (prog_we) written[prog_idx] <= 1'b1;
  end

  function automatic fuse_word_t fetch(input logic [WIDX_W-1:0] idx);
    fuse_word_t w;
    w = '{data: '1, prog: 1'b0};
    if (idx < WIDX_W'(NUM_WORDS) && written[idx[IDX_W-1:0]]) begin
      w.data = mem[idx[IDX_W-1:0]];
      w.prog = 1'b1;
    end
    return w;
  endfunction

  always_comb begin
    rd_a = fetch(rd_idx_a);
    rd_b = fetch(rd_idx_b);
  end
endmodule

// File: rtl/fuse_latches.sv
module fuse_latches (
  input  logic clk,
  input  logic rst_n,
  input  logic set_disable,
  input  logic set_erase,
  output logic win_disabled,
  output logic key_erased
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_disabled <= 1'b0;
      key_erased   <= 1'b0;
    end else begin
      if (set_disable) win_disabled <= 1'b1;
      if (set_erase)   key_erased   <= 1'b1;
    end
  end

  p_disable_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_disabled |=> win_disabled);
  p_erase_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    key_erased |=> key_erased);
endmodule

// File: rtl/fuse_read_mux.sv
module fuse_read_mux
  import fuse_pkg::*;
#(
  parameter int NUM_WORDS = 64
) (
  input  logic [OFF_W-1:0]  offset,
  input  logic              key_erased,
  output logic [WIDX_W-1:0] rd_idx_a,
  output logic [WIDX_W-1:0] rd_idx_b,
  input  fuse_word_t        rd_a,
  input  fuse_word_t        rd_b,
  output logic [31:0]       rdata
);
  logic        lock_a, lock_b;
  logic [31:0] val_a, val_b;
  logic [1:0]  byte_sh;
  logic [63:0] pair;

  function automatic logic locked(input logic [WIDX_W-1:0] idx, input logic erased);
    return (idx >= WIDX_W'(NUM_WORDS)) ||
           (erased && idx >= IDX_ROOT_LO && idx <= IDX_ROOT_HI);
  endfunction

  function automatic logic [31:0] shown(input logic [WIDX_W-1:0] idx,
                                        input fuse_word_t w, input logic erased);
    if (idx == IDX_ERASE) return {31'b0, erased};
    return w.prog ? w.data : 32'hFFFF_FFFF;
  endfunction

  always_comb begin
    rd_idx_a = offset[OFF_W-1:2];
    rd_idx_b = rd_idx_a + WIDX_W'(1);
    byte_sh  = offset[1:0];
    lock_a   = locked(rd_idx_a, key_erased);
    lock_b   = locked(rd_idx_b, key_erased);
    val_a    = shown(rd_idx_a, rd_a, key_erased);
    val_b    = shown(rd_idx_b, rd_b, key_erased);
    pair     = {val_b, val_a} >> {byte_sh, 3'b000};
    if (lock_a || (byte_sh != 2'd0 && lock_b)) rdata = '0;
    else                                        rdata = pair[31:0];
  end
endmodule

// File: rtl/fuse_window.sv
module fuse_window
  import fuse_pkg::*;
#(
  parameter int NUM_WORDS = 64,
  parameter int IDX_W = $clog2(NUM_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_we,
  input  logic [IDX_W-1:0] prog_idx,
  input  logic [31:0]      prog_data,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [31:0]      req_addr,
  input  logic [31:0]      req_wdata,
  input  logic [1:0]       req_priv,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [31:0]      rsp_rdata,
  output logic             rsp_err
);
  logic              accept, in_window, blocked;
  logic              set_disable, set_erase;
  logic              win_disabled, key_erased;
  logic [OFF_W-1:0]  offset;
  logic [WIDX_W-1:0] idx_a, idx_b;
  fuse_word_t        word_a, word_b;
  logic [31:0]       mux_data;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign offset    = req_addr[OFF_W-1:0];
  assign in_window = req_addr[31:OFF_W] == WIN_BASE[31:OFF_W];
  assign blocked   = !in_window || (req_priv != PRIV_MACHINE) || win_disabled;

  assign set_disable = accept && req_write && !blocked &&
                       offset[OFF_W-1:2] == IDX_POLICY && req_wdata[DISABLE_BIT];
  assign set_erase   = accept && req_write && !blocked &&
                       offset[OFF_W-1:2] == IDX_ERASE;

  fuse_array #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_array (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_idx(prog_idx),
    .prog_data(prog_data), .rd_idx_a(idx_a), .rd_idx_b(idx_b),
    .rd_a(word_a), .rd_b(word_b)
  );

  fuse_latches u_latches (
    .clk(clk), .rst_n(rst_n), .set_disable(set_disable), .set_erase(set_erase),
    .win_disabled(win_disabled), .key_erased(key_erased)
  );

  fuse_read_mux #(.NUM_WORDS(NUM_WORDS)) u_mux (
    .offset(offset), .key_erased(key_erased), .rd_idx_a(idx_a), .rd_idx_b(idx_b),
    .rd_a(word_a), .rd_b(word_b), .rdata(mux_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_err   <= blocked;
      rsp_rdata <= (blocked || req_write) ? 32'h0 : mux_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_priv_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_priv != PRIV_MACHINE |=> rsp_valid && rsp_err && rsp_rdata == 32'h0);
  p_disabled_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && win_disabled |=> rsp_valid && rsp_err);
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));
endmodule

// File: tb/fuse_window_tb.sv
module fuse_window_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NW = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_we = 1'b0;
  logic [5:0]  prog_idx = '0;
  logic [31:0] prog_data = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_priv = 2'b11;
  logic        req_ready, rsp_valid, rsp_err;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;

  int tests = 0, fails = 0, cycles = 0;
  bit done = 0;
  logic [31:0] mval [40];
  bit          mprog [40];

  fuse_window u_dut (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_idx(prog_idx),
    .prog_data(prog_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_priv(req_priv), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog: act=%0d cycles exp<=20000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // Expected view of one word index, from the requirements
  function automatic logic [31:0] wview(input int idx, input bit erased, output bit lk);
    lk = (idx >= NW) || (erased && idx >= 4 && idx <= 11);
    if (idx == 13) return {31'b0, erased};
    if (idx < 40 && mprog[idx]) return mval[idx];
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] off, input bit erased);
    bit la, lb;
    logic [31:0] a, b;
    logic [63:0] p;
    a = wview(int'(off[11:2]), erased, la);
    b = wview(int'(off[11:2]) + 1, erased, lb);
    p = {b, a} >> (8 * off[1:0]);
    if (la || (off[1:0] != 0 && lb)) return 32'h0;
    return p[31:0];
  endfunction

  task automatic preload();
    for (int i = 0; i < 40; i++) begin
      mprog[i] = !(i == 3 || (i >= 22 && i <= 31) || i == 13);
      mval[i]  = (i == 0) ? 32'h4F50_5F4F : (32'hA000_0000 | (i << 8) | i);
      if (i == 12) mval[i] = 32'h0000_0003;
      if (mprog[i]) begin
        @(negedge clk);
        prog_we = 1'b1; prog_idx = 6'(i); prog_data = mval[i];
      end
    end
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic do_req(input bit w, input logic [31:0] addr, input logic [31:0] wd,
                        input logic [1:0] priv, output logic [31:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = addr; req_wdata = wd; req_priv = priv;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 rsp_valid one cycle after accept", {31'b0, rsp_valid}, 32'd1);
    rd = rsp_rdata; er = rsp_err;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    preload();
  endtask

  task automatic t_reset_state();
    check("R9 reset rsp_valid low", {31'b0, rsp_valid}, 32'd0);
    check("R9 reset req_ready high", {31'b0, req_ready}, 32'd1);
  endtask

  task automatic t_plain_reads();
    logic [31:0] d; logic e;
    do_req(0, 32'h3000, 0, 2'b11, d, e);
    check("R1 magic word", d, 32'h4F50_5F4F);
    check("R1 no error", {31'b0, e}, 32'd0);
    do_req(0, 32'h3014, 0, 2'b11, d, e);
    check("R1 root hash word", d, mval[5]);
    do_req(0, 32'h300C, 0, 2'b11, d, e);
    check("R2 unprogrammed word", d, 32'hFFFF_FFFF);
    do_req(0, 32'h3034, 0, 2'b11, d, e);
    check("R4 erase word before latch", d, 32'h0);
  endtask

  task automatic t_misaligned();
    logic [31:0] d; logic e;
    do_req(0, 32'h3001, 0, 2'b11, d, e);
    check("R5 misaligned by 1", d, exp_read(12'h001, 0));
    do_req(0, 32'h300E, 0, 2'b11, d, e);
    check("R5 misaligned into unprogrammed", d, exp_read(12'h00E, 0));
    do_req(0, 32'h3031, 0, 2'b11, d, e);
    check("R5 misaligned into erase word", d, exp_read(12'h031, 0));
  endtask

  task automatic t_range();
    logic [31:0] d; logic e;
    do_req(0, 32'h4000, 0, 2'b11, d, e);
    check("R8 outside window error", {31'b0, e}, 32'd1);
    check("R8 outside window data", d, 32'h0);
    do_req(0, 32'h3100, 0, 2'b11, d, e);
    check("R8 past array zero", d, 32'h0);
    check("R8 past array no error", {31'b0, e}, 32'd0);
    do_req(0, 32'h30FE, 0, 2'b11, d, e);
    check("R5 misaligned crossing past array", d, 32'h0);
  endtask

  task automatic t_ignored_writes();
    logic [31:0] d; logic e;
    do_req(1, 32'h3000, 32'h1234_5678, 2'b11, d, e);
    check("R7 ro write no error", {31'b0, e}, 32'd0);
    do_req(0, 32'h3000, 0, 2'b11, d, e);
    check("R7 word unchanged", d, 32'h4F50_5F4F);
    do_req(1, 32'h3030, 32'hFFFF_FFF7, 2'b11, d, e);
    do_req(0, 32'h3030, 0, 2'b11, d, e);
    check("R6 bit3 clear leaves window open", {31'b0, e}, 32'd0);
    check("R6 policy word readable", d, mval[12]);
  endtask

  task automatic t_priv();
    logic [31:0] d; logic e;
    do_req(0, 32'h3000, 0, 2'b01, d, e);
    check("R3 supervisor read error", {31'b0, e}, 32'd1);
    check("R3 supervisor read data", d, 32'h0);
    do_req(1, 32'h3034, 32'h1, 2'b00, d, e);
    check("R3 user write error", {31'b0, e}, 32'd1);
    do_req(0, 32'h3010, 0, 2'b11, d, e);
    check("R3 user write did not erase", d, mval[4]);
    do_req(1, 32'h3030, 32'h8, 2'b01, d, e);
    do_req(0, 32'h3000, 0, 2'b11, d, e);
    check("R3 supervisor write did not disable", {31'b0, e}, 32'd0);
  endtask

  task automatic t_backpressure();
    logic [31:0] d0;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h3004; req_priv = 2'b11;
    @(negedge clk);
    req_valid = 1'b0;
    d0 = rsp_rdata;
    check("R1 stalled response data", d0, mval[1]);
    repeat (3) @(negedge clk);
    check("R9 held valid", {31'b0, rsp_valid}, 32'd1);
    check("R9 req_ready low", {31'b0, req_ready}, 32'd0);
    check("R9 data stable", rsp_rdata, d0);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R9 drained", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic t_erase();
    logic [31:0] d; logic e;
    do_req(1, 32'h3034, 32'h0, 2'b11, d, e);
    check("R4 erase write no error", {31'b0, e}, 32'd0);
    do_req(0, 32'h3010, 0, 2'b11, d, e);
    check("R4 root low word zero", d, 32'h0);
    do_req(0, 32'h302C, 0, 2'b11, d, e);
    check("R4 root high word zero", d, 32'h0);
    do_req(0, 32'h3034, 0, 2'b11, d, e);
    check("R4 erase word reads 1", d, 32'h1);
    do_req(0, 32'h3040, 0, 2'b11, d, e);
    check("R4 chip id untouched", d, mval[16]);
    do_req(0, 32'h300E, 0, 2'b11, d, e);
    check("R5 crossing into erased hash", d, 32'h0);
    do_req(0, 32'h302E, 0, 2'b11, d, e);
    check("R5 crossing out of erased hash", d, 32'h0);
  endtask

  task automatic t_disable();
    logic [31:0] d; logic e;
    do_req(1, 32'h3030, 32'h8, 2'b11, d, e);
    check("R6 disabling write no error", {31'b0, e}, 32'd0);
    do_req(0, 32'h3000, 0, 2'b11, d, e);
    check("R6 disabled read error", {31'b0, e}, 32'd1);
    check("R6 disabled read data", d, 32'h0);
    do_req(0, 32'h3040, 0, 2'b11, d, e);
    check("R6 disabled stays", {31'b0, e}, 32'd1);
  endtask

  task automatic t_reset_clears();
    logic [31:0] d; logic e;
    do_reset();
    do_req(0, 32'h3010, 0, 2'b11, d, e);
    check("R10 window open after reset", {31'b0, e}, 32'd0);
    check("R10 root hash readable after reset", d, mval[4]);
    do_req(0, 32'h3034, 0, 2'b11, d, e);
    check("R10 erase latch cleared", d, 32'h0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    preload();
    t_plain_reads();
    t_misaligned();
    t_range();
    t_ignored_writes();
    t_priv();
    t_backpressure();
    t_erase();
    t_disable();
    t_reset_clears();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule